// File: doc/BRIEF.md
# Delayed Transaction Retry Arbiter

This block sits on the target side of a bus bridge. For every incoming read or delayed write, it decides in one cycle whether to complete the transaction or to answer with a target retry. It keeps a small table of outstanding delayed transactions, indexed by full address and 4-bit command. The first attempt of a new transaction is answered with retry and enters the table. Repeat attempts get retry until their completion has arrived and is the oldest completion not yet handed back. At that point the attempt is accepted and its entry is released. Two lock rules can force a retry on writes before the table is consulted.

Each table slot is a small state machine with three states:
- `SLOT_EMPTY`: free.
- `SLOT_WAIT`: queued, no response yet.
- `SLOT_DONE`: response held.

A slot moves through these transitions:
- alloc: `SLOT_EMPTY` to `SLOT_WAIT`, on a retried new request.
- complete: `SLOT_WAIT` to `SLOT_DONE`, on a completion with equal address and command.
- release: `SLOT_DONE` to `SLOT_EMPTY`, on an accepted request.

Completions are numbered in the order they arrive. A head pointer selects the completion that may be handed back next.

Each request is classified into exactly one outcome. They are tested in this priority order:
1. `DEC_LOCKED`: lock rule fires.
2. `DEC_HEAD_HIT`: matches the head completion.
3. `DEC_PEND_HIT`: matches an entry that is waiting or not at the head.
4. `DEC_FULL`: no match and no free slot.
5. `DEC_NEW`: no match and a free slot.

Top module: `dt_retry_arb`

## Requirements
- R1: One cycle after each cycle with `req_valid` high, `dec_valid` is high and exactly one of `dec_accept` and `dec_retry` is high. `dec_valid` is low one cycle after a cycle with `req_valid` low.
- R2: A request that matches no entry while a slot is free is answered with retry, `q_enter` is high, and the transaction occupies a slot.
- R3: A request matching an entry whose completion has not arrived is answered with retry, and `q_enter` is low.
- R4: A request matching an entry whose completion has arrived but is not the oldest unreturned completion is answered with retry, and `q_enter` is low.
- R5: A request matching the oldest unreturned completion is accepted, and its slot is released. A later identical request is treated as new.
- R6: When all DEPTH slots are occupied, a non-matching request is answered with retry and `q_enter` is low.
- R7: A write with `req_lock` low while `lock_prop` is high is answered with retry, `q_enter` is low, and the table is unchanged.
- R8: A write with `req_lock` high while `tgt_locked` is high is answered with retry, and `q_enter` is low.
- R9: Matching compares all AW address bits and all 4 command bits. A request differing in either is treated as a different transaction.
- R10: Reads are never affected by `lock_prop` or `tgt_locked`.
- R11: After reset all slots are empty, and `dec_valid`, `dec_accept`, `dec_retry` and `q_enter` are low.
- R12: Completions are handed back in the order they arrived, regardless of the order in which entries were queued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request attempt present this cycle |
| req_addr | input | AW | Request address |
| req_cmd | input | 4 | Request command |
| req_write | input | 1 | 1 = write, 0 = read |
| req_lock | input | 1 | Request is part of a locked sequence |
| lock_prop | input | 1 | A locked sequence is being carried across the bridge |
| tgt_locked | input | 1 | Target bus is currently locked |
| cpl_valid | input | 1 | Target response arrives this cycle |
| cpl_addr | input | AW | Address of the response |
| cpl_cmd | input | 4 | Command of the response |
| dec_valid | output | 1 | Decision present (one cycle after the request) |
| dec_accept | output | 1 | Request accepted |
| dec_retry | output | 1 | Request answered with target retry |
| q_enter | output | 1 | Request was entered into the table |

## Verification
Every decision is registered and appears in the cycle after its request. Slot changes made by a request or a completion take effect at the same edge, so the request issued in the next cycle already sees them. The driver presents each request for one cycle starting on a falling edge and pushes the expected decision into a scoreboard queue. The monitor samples just after the following falling edge: one rising edge after the request, which is the edge that loads the outputs. On each cycle where `dec_valid` is high, the monitor pops one item from the queue and compares it. A decision that arrives with nothing expected is counted as a miscompare. So is an expected decision that never arrives.

// File: rtl/dt_pkg.sv
package dt_pkg;
    localparam int CMD_W = 4;

    typedef enum logic [1:0] {
        SLOT_EMPTY,
        SLOT_WAIT,
        SLOT_DONE
    } slot_state_e;

    typedef enum logic [2:0] {
        DEC_LOCKED,
        DEC_HEAD_HIT,
        DEC_PEND_HIT,
        DEC_FULL,
        DEC_NEW
    } dec_kind_e;
endpackage

// File: rtl/dt_first_free.sv
module dt_first_free #(
    parameter int N  = 4,
    parameter int IW = 2
) (
    input  logic [N-1:0]  busy_i,
    output logic [IW-1:0] idx_o,
    output logic          full_o
);
    always_comb begin
        idx_o  = '0;
        full_o = 1'b1;
        for (int i = N - 1; i >= 0; i--) begin
            if (!busy_i[i]) begin
                idx_o  = IW'(i);
                full_o = 1'b0;
            end
        end
    end
endmodule

// File: rtl/dt_slot.sv
module dt_slot
    import dt_pkg::*;
#(
    parameter int AW = 32,
    parameter int SW = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             alloc_i,
    input  logic             free_i,
    input  logic [AW-1:0]    req_addr,
    input  logic [CMD_W-1:0] req_cmd,
    input  logic             cpl_valid,
    input  logic [AW-1:0]    cpl_addr,
    input  logic [CMD_W-1:0] cpl_cmd,
    input  logic [SW-1:0]    cpl_seq_i,
    output logic             busy_o,
    output logic             done_o,
    output logic             hit_o,
    output logic             cpl_hit_o,
    output logic [SW-1:0]    seq_o
);
    slot_state_e          st_q, st_d;
    logic [AW-1:0]        addr_q;
    logic [CMD_W-1:0]     cmd_q;
    logic [SW-1:0]        seq_q;

    assign busy_o    = (st_q != SLOT_EMPTY);
    assign done_o    = (st_q == SLOT_DONE);
    assign hit_o     = busy_o && (addr_q == req_addr) && (cmd_q == req_cmd);
    assign cpl_hit_o = (st_q == SLOT_WAIT) && cpl_valid &&
                       (addr_q == cpl_addr) && (cmd_q == cpl_cmd);
    assign seq_o     = seq_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= SLOT_EMPTY;
            addr_q <= '0;
            cmd_q  <= '0;
            seq_q  <= '0;
        end else begin
            st_q <= st_d;
            if (alloc_i) begin
                addr_q <= req_addr;
                cmd_q  <= req_cmd;
            end
            if (cpl_hit_o) seq_q <= cpl_seq_i;
        end
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            SLOT_EMPTY: if (alloc_i)   st_d = SLOT_WAIT;
            SLOT_WAIT:  if (cpl_hit_o) st_d = SLOT_DONE;
            SLOT_DONE:  if (free_i)    st_d = SLOT_EMPTY;
            default:                   st_d = SLOT_EMPTY;
        endcase
    end

    AST_ALLOC_ONLY_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_i |-> (st_q == SLOT_EMPTY)); // R2
    AST_NO_DONE_FROM_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == SLOT_EMPTY) |=> (st_q != SLOT_DONE)); // R3
    AST_FREE_ONLY_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        free_i |-> (st_q == SLOT_DONE)); // R5
endmodule

// File: rtl/dt_retry_arb.sv
module dt_retry_arb
    import dt_pkg::*;
#(
    parameter int AW    = 32,
    parameter int DEPTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [AW-1:0]    req_addr,
    input  logic [CMD_W-1:0] req_cmd,
    input  logic             req_write,
    input  logic             req_lock,
    input  logic             lock_prop,
    input  logic             tgt_locked,
    input  logic             cpl_valid,
    input  logic [AW-1:0]    cpl_addr,
    input  logic [CMD_W-1:0] cpl_cmd,
    output logic             dec_valid,
    output logic             dec_accept,
    output logic             dec_retry,
    output logic             q_enter
);
    localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int SW = $clog2(DEPTH) + 1;

    logic [DEPTH-1:0] busy_v, done_v, hit_v, cpl_hit_v, alloc_v, free_v;
    logic [SW-1:0]    seq_a [DEPTH];
    logic [SW-1:0]    head_q, tail_q;
    logic [IW-1:0]    free_idx, hit_idx;
    logic             full, any_hit, hit_head, lock_block;
    logic             nxt_accept, nxt_enter;
    dec_kind_e        kind;

    dt_first_free #(.N(DEPTH), .IW(IW)) u_pick (
        .busy_i (busy_v),
        .idx_o  (free_idx),
        .full_o (full)
    );

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        dt_slot #(.AW(AW), .SW(SW)) u_slot (
            .clk       (clk),
            .rst_n     (rst_n),
            .alloc_i   (alloc_v[g]),
            .free_i    (free_v[g]),
            .req_addr  (req_addr),
            .req_cmd   (req_cmd),
            .cpl_valid (cpl_valid),
            .cpl_addr  (cpl_addr),
            .cpl_cmd   (cpl_cmd),
            .cpl_seq_i (tail_q),
            .busy_o    (busy_v[g]),
            .done_o    (done_v[g]),
            .hit_o     (hit_v[g]),
            .cpl_hit_o (cpl_hit_v[g]),
            .seq_o     (seq_a[g])
        );
    end

    always_comb begin
        hit_idx = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (hit_v[i]) hit_idx = IW'(i);
        end
    end

    assign any_hit    = |hit_v;
    assign hit_head   = done_v[hit_idx] && (seq_a[hit_idx] == head_q);
    assign lock_block = req_write &&
                        ((!req_lock && lock_prop) || (req_lock && tgt_locked));

    always_comb begin
        if (lock_block)    kind = DEC_LOCKED;
        else if (any_hit)  kind = hit_head ? DEC_HEAD_HIT : DEC_PEND_HIT;
        else if (full)     kind = DEC_FULL;
        else               kind = DEC_NEW;
    end

    always_comb begin
        nxt_accept = 1'b0;
        nxt_enter  = 1'b0;
        alloc_v    = '0;
        free_v     = '0;
        unique case (kind)
            DEC_LOCKED:   ;
            DEC_HEAD_HIT: begin
                nxt_accept = 1'b1;
                free_v[hit_idx] = req_valid;
            end
            DEC_PEND_HIT: ;
            DEC_FULL:     ;
            DEC_NEW: begin
                nxt_enter = 1'b1;
                alloc_v[free_idx] = req_valid;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head_q     <= '0;
            tail_q     <= '0;
            dec_valid  <= 1'b0;
            dec_accept <= 1'b0;
            dec_retry  <= 1'b0;
            q_enter    <= 1'b0;
        end else begin
            if (|cpl_hit_v) tail_q <= tail_q + 1'b1;
            if (|free_v)    head_q <= head_q + 1'b1;
            dec_valid  <= req_valid;
            dec_accept <= req_valid && nxt_accept;
            dec_retry  <= req_valid && !nxt_accept;
            q_enter    <= req_valid && nxt_enter;
        end
    end

    AST_ONE_DECISION: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid |-> (dec_accept != dec_retry)); // R1
    AST_DEC_TRACKS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> dec_valid); // R1
    AST_ENTER_WITH_RETRY: assert property (@(posedge clk) disable iff (!rst_n)
        q_enter |-> dec_retry); // R2
    AST_FULL_NO_ENTER: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && full) |=> !q_enter); // R6
    AST_LOCK_PROP_RETRY: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && !req_lock && lock_prop) |=> (dec_retry && !q_enter)); // R7
    AST_TGT_LOCK_RETRY: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && req_lock && tgt_locked) |=> (dec_retry && !q_enter)); // R8
    AST_ONE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(free_v)); // R5
endmodule

// File: tb/tb_dt_retry_arb.sv
`timescale 1ns/1ps
module tb_dt_retry_arb;
    localparam int AW = 32;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          req_valid, req_write, req_lock, lock_prop, tgt_locked, cpl_valid;
    logic [AW-1:0] req_addr, cpl_addr;
    logic [3:0]    req_cmd, cpl_cmd;
    logic          dec_valid, dec_accept, dec_retry, q_enter;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    logic [2:0] sb_exp [$];
    string      sb_tag [$];

    always #4 clk = ~clk;

    dt_retry_arb #(.AW(AW), .DEPTH(4)) dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_addr(req_addr), .req_cmd(req_cmd),
        .req_write(req_write), .req_lock(req_lock),
        .lock_prop(lock_prop), .tgt_locked(tgt_locked),
        .cpl_valid(cpl_valid), .cpl_addr(cpl_addr), .cpl_cmd(cpl_cmd),
        .dec_valid(dec_valid), .dec_accept(dec_accept),
        .dec_retry(dec_retry), .q_enter(q_enter)
    );

    task automatic check(input string tag, input logic [3:0] act, input logic [3:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual {valid,acc,retry,enter}=%b expected %b", tag, act, exp);
        end
    endtask

    // expected = {accept, retry, enter}
    task automatic issue(input logic [AW-1:0] a, input logic [3:0] c, input logic w,
                         input logic lk, input logic [2:0] exp, input string tag);
        sb_exp.push_back(exp);
        sb_tag.push_back(tag);
        req_valid = 1'b1; req_addr = a; req_cmd = c; req_write = w; req_lock = lk;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic complete(input logic [AW-1:0] a, input logic [3:0] c);
        cpl_valid = 1'b1; cpl_addr = a; cpl_cmd = c;
        @(negedge clk);
        cpl_valid = 1'b0;
    endtask

    // monitor
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (rst_n === 1'b1 && dec_valid === 1'b1) begin
                if (sb_exp.size() == 0) begin
                    check("R1 unexpected decision", {dec_valid, dec_accept, dec_retry, q_enter}, 4'b0000);
                end else begin
                    logic [2:0] e;
                    string t;
                    e = sb_exp.pop_front();
                    t = sb_tag.pop_front();
                    check(t, {dec_valid, dec_accept, dec_retry, q_enter}, {1'b1, e});
                end
            end
        end
    end

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    localparam logic [2:0] E_NEW  = 3'b011;
    localparam logic [2:0] E_RTY  = 3'b010;
    localparam logic [2:0] E_ACC  = 3'b100;

    initial begin
        rst_n = 1'b0; req_valid = 0; req_write = 0; req_lock = 0;
        lock_prop = 0; tgt_locked = 0; cpl_valid = 0;
        req_addr = '0; req_cmd = '0; cpl_addr = '0; cpl_cmd = '0;
        repeat (3) @(negedge clk);
        check("R11 reset outputs", {dec_valid, dec_accept, dec_retry, q_enter}, 4'b0000);
        rst_n = 1'b1;
        @(negedge clk);

        issue(32'h1000_0040, 4'h6, 0, 0, E_NEW, "R2 first attempt enters");
        issue(32'h1000_0040, 4'h6, 0, 0, E_RTY, "R3 queued awaiting response");
        issue(32'h1000_0040, 4'h7, 0, 0, E_NEW, "R9 other command is new");
        issue(32'h1000_0044, 4'h6, 0, 0, E_NEW, "R9 other address is new");
        issue(32'h2000_0000, 4'h7, 1, 0, E_NEW, "R2 write enters");
        issue(32'h3000_0000, 4'h6, 0, 0, E_RTY, "R6 table full");
        complete(32'h1000_0040, 4'h7);
        complete(32'h1000_0040, 4'h6);
        #1;
        check("R1 no decision while idle", {dec_valid, dec_accept, dec_retry, q_enter}, 4'b0000);
        issue(32'h1000_0040, 4'h6, 0, 0, E_RTY, "R4 done but not head");
        issue(32'h1000_0040, 4'h7, 0, 0, E_ACC, "R12 first completion returned");
        issue(32'h1000_0040, 4'h7, 0, 0, E_NEW, "R5 freed entry is new again");
        issue(32'h1000_0040, 4'h6, 0, 0, E_ACC, "R12 second completion returned");

        lock_prop = 1'b1;
        issue(32'h5000_0000, 4'h7, 1, 0, E_RTY, "R7 unlocked write during lock");
        issue(32'h5000_0010, 4'h6, 0, 0, E_NEW, "R10 read ignores lock_prop");
        lock_prop = 1'b0;
        issue(32'h5000_0000, 4'h7, 1, 0, E_RTY, "R7 blocked write left table unchanged (full now)");

        complete(32'h1000_0044, 4'h6);
        complete(32'h2000_0000, 4'h7);
        issue(32'h1000_0044, 4'h6, 0, 0, E_ACC, "R5 head accept");
        issue(32'h2000_0000, 4'h7, 1, 0, E_ACC, "R12 order kept");
        issue(32'h5000_0000, 4'h7, 1, 0, E_NEW, "R7 write enters once lock ends");

        tgt_locked = 1'b1;
        issue(32'h6000_0000, 4'h7, 1, 1, E_RTY, "R8 locked write on locked target");
        issue(32'h6000_0000, 4'h6, 0, 1, E_NEW, "R10 read ignores tgt_locked");
        tgt_locked = 1'b0;
        issue(32'h7000_0000, 4'h6, 0, 0, E_RTY, "R6 full again");

        repeat (3) @(negedge clk);
        check("R1 all decisions seen", {1'b0, sb_exp.size() != 0, 2'b00}, 4'b0000);
        finish_run();
    end
endmodule